// File: doc/BRIEF.md
# Kernel Segment Address Translator

This block turns a 32-bit virtual address into a physical one. The top address bits pick one of sixteen segments. Each segment is configured for one of two kinds of translation. A direct segment swaps the top nibble of the address for a programmed base nibble and keeps the low 28 bits unchanged. A paged segment sends the virtual page number to an external page-lookup port. It then combines the returned frame number with the 13-bit page offset.

Accesses arrive on a valid/ready request channel with a user/kernel flag. Results leave on a valid/ready response channel, in the order the requests were accepted. A kernel access can reach the whole 4 GB space. A user access to segment B or above is refused with a fault and is never translated. A page-lookup miss also comes back as a fault. Every fault response carries the original virtual address and a cause code.

Back-pressure works as follows. The block holds at most one transaction in flight. A response stays on the port, unchanged, until `rsp_ready` is high. New requests are refused in two cases: while a page lookup is outstanding, and while a held response is not being taken in the same cycle. The page-lookup request follows the same rule and stays stable until `pg_req_ready` is high. The page-lookup response has no ready signal, because the block is always waiting for it when it arrives.

Top module: `kseg_xlate`

## Requirements
- R1: The segment index is address bits 31:28. For a segment in direct mode, the physical address is that segment's 4-bit base placed in bits 31:28, with virtual bits 27:0 copied unchanged.
- R2: Mode bit n (1 = direct, 0 = paged) controls segment n. After reset every segment is paged and every base is zero. After reset, `req_ready` is 1 and `rsp_valid` and `pg_req_valid` are 0.
- R3: A configuration write happens at a clock edge with `cfg_we` high. `cfg_sel` 0 loads the mode bits from `cfg_wdata[15:0]`. `cfg_sel` 1 loads the base of segment i (0..7) from bits 4i+3:4i. `cfg_sel` 2 loads the base of segment 8+i from the same nibble position. Requests accepted at that same edge still use the old settings; requests accepted at later edges use the new ones.
- R4: If `req_user` is 1 and the segment index is 11 or higher, the response has `rsp_cause` = 1 (user boundary) and `rsp_addr` equal to the virtual address, and no page lookup is issued. A kernel access is never refused this way.
- R5: A kernel access, or a permitted user access, to a paged segment raises `pg_req_valid` with `pg_req_vpn` equal to virtual bits 31:13. On a hit, the response is `{pg_rsp_frame, virtual bits 12:0}` with `rsp_cause` = 0.
- R6: If the page-lookup response has `pg_rsp_miss` = 1, the response has `rsp_cause` = 2 (page miss) and `rsp_addr` equal to the virtual address.
- R7: A direct-mode access or a user-boundary fault sets `rsp_valid` in the cycle right after acceptance, with no page lookup.
- R8: While `rsp_valid` is 1 and `rsp_ready` is 0, the response stays unchanged. `req_ready` is 0 while a page lookup is outstanding. Responses come out in acceptance order.
- R9: While `pg_req_valid` is 1 and `pg_req_ready` is 0, `pg_req_valid` stays high and `pg_req_vpn` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Target: 0 mode, 1 low bases, 2 high bases |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | 32 | Virtual address |
| req_user | input | 1 | 1 = user access, 0 = kernel access |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_addr | output | 32 | Physical address, or virtual address on a fault |
| rsp_cause | output | 2 | 0 ok, 1 user boundary, 2 page miss |
| pg_req_valid | output | 1 | Page lookup request valid |
| pg_req_ready | input | 1 | Page lookup request accepted |
| pg_req_vpn | output | 19 | Virtual page number |
| pg_rsp_valid | input | 1 | Page lookup result valid |
| pg_rsp_frame | input | 19 | Physical frame number |
| pg_rsp_miss | input | 1 | Lookup found no mapping |

## Verification
The bench builds the block with its defaults: 32-bit addresses, four segment bits, 13-bit offsets and the user limit at segment 11. These values make every segment index, both sides of the user boundary at 0xAFFFFFFF/0xB0000000, and the full range of base nibbles reachable from ordinary addresses. A behavioural model holds its own copy of the configuration. It predicts each response from the address, the user flag and a deterministic frame/miss function of the page number. In the stress phase, random stalls on both ready inputs and random lookup latencies exercise the hold and ordering rules alongside configuration rewrites.

// File: rtl/kseg_pkg.sv
package kseg_pkg;

  // Fault cause reported with every response
  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_USER = 2'd1,
    CAUSE_MISS = 2'd2
  } cause_e;

  // Configuration write targets
  typedef enum logic [1:0] {
    CFG_MODE    = 2'd0,
    CFG_BASE_LO = 2'd1,
    CFG_BASE_HI = 2'd2
  } cfg_sel_e;

  // How an accepted request is handled
  typedef enum logic [1:0] {
    ROUTE_DIRECT = 2'd0,
    ROUTE_PAGED  = 2'd1,
    ROUTE_FAULT  = 2'd2
  } route_e;

endpackage

// File: rtl/kseg_cfg_regs.sv
module kseg_cfg_regs #(
  parameter int SEG_BITS = 4,
  parameter int CFG_W    = 32
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cfg_we,
  input  logic [1:0]                         cfg_sel,
  input  logic [CFG_W-1:0]                   cfg_wdata,
  output logic [(1<<SEG_BITS)-1:0]           seg_mode,
  output logic [(1<<SEG_BITS)*SEG_BITS-1:0]  seg_base
);
  import kseg_pkg::*;

  localparam int NSEG = 1 << SEG_BITS;
  localparam int HALF = NSEG / 2;

  logic wr_mode;
  assign wr_mode = cfg_we && (cfg_sel == CFG_MODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_mode <= '0;
    end else if (wr_mode) begin
      seg_mode <= cfg_wdata[NSEG-1:0];
    end
  end

  // One base nibble per segment; lower half from one word, upper half from another
  for (genvar g = 0; g < NSEG; g++) begin : g_base
    localparam int       SLOT   = g % HALF;
    localparam cfg_sel_e MY_SEL = (g >= HALF) ? CFG_BASE_HI : CFG_BASE_LO;
    logic [SEG_BITS-1:0] base_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q <= '0;
      end else if (cfg_we && (cfg_sel == MY_SEL)) begin
        base_q <= cfg_wdata[SLOT*SEG_BITS +: SEG_BITS];
      end
    end

    assign seg_base[g*SEG_BITS +: SEG_BITS] = base_q;
  end

endmodule

// File: rtl/kseg_seg_decode.sv
module kseg_seg_decode #(
  parameter int ADDR_W         = 32,
  parameter int SEG_BITS       = 4,
  parameter int USER_LIMIT_SEG = 11
) (
  input  logic [ADDR_W-1:0]                  addr,
  input  logic                               user,
  input  logic [(1<<SEG_BITS)-1:0]           seg_mode,
  input  logic [(1<<SEG_BITS)*SEG_BITS-1:0]  seg_base,
  output kseg_pkg::route_e                   route,
  output logic [ADDR_W-1:0]                  direct_addr
);
  import kseg_pkg::*;

  localparam int                  NSEG  = 1 << SEG_BITS;
  localparam int                  LOW_W = ADDR_W - SEG_BITS;
  localparam logic [SEG_BITS-1:0] LIMIT = SEG_BITS'(USER_LIMIT_SEG);

  logic [SEG_BITS-1:0] base_arr [NSEG];
  logic [SEG_BITS-1:0] seg;
  logic                user_blocked;

  for (genvar g = 0; g < NSEG; g++) begin : g_unpack
    assign base_arr[g] = seg_base[g*SEG_BITS +: SEG_BITS];
  end

  assign seg          = addr[ADDR_W-1 -: SEG_BITS];
  assign user_blocked = user && (seg >= LIMIT);
  assign direct_addr  = {base_arr[seg], addr[LOW_W-1:0]};

  always_comb begin
    if (user_blocked)        route = ROUTE_FAULT;
    else if (seg_mode[seg])  route = ROUTE_DIRECT;
    else                     route = ROUTE_PAGED;
  end

endmodule

// File: rtl/kseg_ctrl.sv
module kseg_ctrl #(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 13
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [ADDR_W-1:0]           req_addr,
  input  kseg_pkg::route_e            route,
  input  logic [ADDR_W-1:0]           direct_addr,
  output logic                        rsp_valid,
  input  logic                        rsp_ready,
  output logic [ADDR_W-1:0]           rsp_addr,
  output logic [1:0]                  rsp_cause,
  output logic                        pg_req_valid,
  input  logic                        pg_req_ready,
  output logic [ADDR_W-PAGE_BITS-1:0] pg_req_vpn,
  input  logic                        pg_rsp_valid,
  input  logic [ADDR_W-PAGE_BITS-1:0] pg_rsp_frame,
  input  logic                        pg_rsp_miss
);
  import kseg_pkg::*;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} state_e;

  state_e            state_q;
  logic [ADDR_W-1:0] vaddr_q;
  logic              out_free;
  logic              accept;

  assign out_free     = !rsp_valid || rsp_ready;
  assign req_ready    = (state_q == ST_IDLE) && out_free;
  assign accept       = req_valid && req_ready;
  assign pg_req_valid = (state_q == ST_ISSUE);
  assign pg_req_vpn   = vaddr_q[ADDR_W-1:PAGE_BITS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      vaddr_q   <= '0;
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_cause <= CAUSE_NONE;
    end else begin
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            vaddr_q <= req_addr;
            case (route)
              ROUTE_DIRECT: begin
                rsp_valid <= 1'b1;
                rsp_addr  <= direct_addr;
                rsp_cause <= CAUSE_NONE;
              end
              ROUTE_FAULT: begin
                rsp_valid <= 1'b1;
                rsp_addr  <= req_addr;
                rsp_cause <= CAUSE_USER;
              end
              default: state_q <= ST_ISSUE;
            endcase
          end
        end
        ST_ISSUE: begin
          if (pg_req_ready) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          // Output slot is empty here: it was free when this request was taken
          if (pg_rsp_valid) begin
            rsp_valid <= 1'b1;
            state_q   <= ST_IDLE;
            if (pg_rsp_miss) begin
              rsp_addr  <= vaddr_q;
              rsp_cause <= CAUSE_MISS;
            end else begin
              rsp_addr  <= {pg_rsp_frame, vaddr_q[PAGE_BITS-1:0]};
              rsp_cause <= CAUSE_NONE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/kseg_xlate.sv
module kseg_xlate #(
  parameter int  ADDR_W         = 32,
  parameter int  SEG_BITS       = 4,
  parameter int  PAGE_BITS      = 13,
  parameter int  USER_LIMIT_SEG = 11,
  localparam int NSEG           = 1 << SEG_BITS,
  localparam int CFG_W          = (NSEG / 2) * SEG_BITS,
  localparam int VPN_W          = ADDR_W - PAGE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_user,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [1:0]        rsp_cause,
  output logic              pg_req_valid,
  input  logic              pg_req_ready,
  output logic [VPN_W-1:0]  pg_req_vpn,
  input  logic              pg_rsp_valid,
  input  logic [VPN_W-1:0]  pg_rsp_frame,
  input  logic              pg_rsp_miss
);
  import kseg_pkg::*;

  logic [NSEG-1:0]          seg_mode;
  logic [NSEG*SEG_BITS-1:0] seg_base;
  route_e                   route;
  logic [ADDR_W-1:0]        direct_addr;

  kseg_cfg_regs #(
    .SEG_BITS (SEG_BITS),
    .CFG_W    (CFG_W)
  ) cfg_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .seg_mode  (seg_mode),
    .seg_base  (seg_base)
  );

  kseg_seg_decode #(
    .ADDR_W         (ADDR_W),
    .SEG_BITS       (SEG_BITS),
    .USER_LIMIT_SEG (USER_LIMIT_SEG)
  ) dec_i (
    .addr        (req_addr),
    .user        (req_user),
    .seg_mode    (seg_mode),
    .seg_base    (seg_base),
    .route       (route),
    .direct_addr (direct_addr)
  );

  kseg_ctrl #(
    .ADDR_W    (ADDR_W),
    .PAGE_BITS (PAGE_BITS)
  ) ctrl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_addr     (req_addr),
    .route        (route),
    .direct_addr  (direct_addr),
    .rsp_valid    (rsp_valid),
    .rsp_ready    (rsp_ready),
    .rsp_addr     (rsp_addr),
    .rsp_cause    (rsp_cause),
    .pg_req_valid (pg_req_valid),
    .pg_req_ready (pg_req_ready),
    .pg_req_vpn   (pg_req_vpn),
    .pg_rsp_valid (pg_rsp_valid),
    .pg_rsp_frame (pg_rsp_frame),
    .pg_rsp_miss  (pg_rsp_miss)
  );

endmodule

// File: rtl/kseg_xlate_chk.sv
module kseg_xlate_chk #(
  parameter int ADDR_W         = 32,
  parameter int SEG_BITS       = 4,
  parameter int PAGE_BITS      = 13,
  parameter int USER_LIMIT_SEG = 11
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        req_valid,
  input logic                        req_ready,
  input logic [ADDR_W-1:0]           req_addr,
  input logic                        req_user,
  input logic                        rsp_valid,
  input logic                        rsp_ready,
  input logic [ADDR_W-1:0]           rsp_addr,
  input logic [1:0]                  rsp_cause,
  input logic                        pg_req_valid,
  input logic                        pg_req_ready,
  input logic [ADDR_W-PAGE_BITS-1:0] pg_req_vpn,
  input logic [(1<<SEG_BITS)-1:0]    seg_mode
);
  localparam int                  LOW_W = ADDR_W - SEG_BITS;
  localparam logic [SEG_BITS-1:0] LIMIT = SEG_BITS'(USER_LIMIT_SEG);

  logic                accept;
  logic [SEG_BITS-1:0] seg_in;
  logic                blocked;

  assign accept  = req_valid && req_ready;
  assign seg_in  = req_addr[ADDR_W-1 -: SEG_BITS];
  assign blocked = req_user && (seg_in >= LIMIT);

  assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_cause));

  assert_no_accept_during_lookup_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pg_req_valid |-> !req_ready);

  assert_pg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pg_req_valid && !pg_req_ready |=> pg_req_valid && $stable(pg_req_vpn));

  assert_user_fence_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && blocked |=> rsp_valid && rsp_cause == 2'd1 && rsp_addr == $past(req_addr)
                          && !pg_req_valid);

  assert_direct_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !blocked && seg_mode[seg_in] |=> rsp_valid && rsp_cause == 2'd0
      && rsp_addr[LOW_W-1:0] == $past(req_addr[LOW_W-1:0]) && !pg_req_valid);

  assert_paged_issue_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !blocked && !seg_mode[seg_in] |=> pg_req_valid
      && pg_req_vpn == $past(req_addr[ADDR_W-1:PAGE_BITS]));

  assert_cause_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_cause != 2'd3);

endmodule

bind kseg_xlate kseg_xlate_chk #(
  .ADDR_W         (ADDR_W),
  .SEG_BITS       (SEG_BITS),
  .PAGE_BITS      (PAGE_BITS),
  .USER_LIMIT_SEG (USER_LIMIT_SEG)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_addr     (req_addr),
  .req_user     (req_user),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_addr     (rsp_addr),
  .rsp_cause    (rsp_cause),
  .pg_req_valid (pg_req_valid),
  .pg_req_ready (pg_req_ready),
  .pg_req_vpn   (pg_req_vpn),
  .seg_mode     (seg_mode)
);

// File: tb/kseg_xlate_tb_top.sv
`timescale 1ns/1ps
module kseg_xlate_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = 32'd0;
  logic        req_user = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_addr;
  logic [1:0]  rsp_cause;
  logic        pg_req_valid;
  logic        pg_req_ready = 1'b1;
  logic [18:0] pg_req_vpn;
  logic        pg_rsp_valid = 1'b0;
  logic [18:0] pg_rsp_frame = 19'd0;
  logic        pg_rsp_miss = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  kseg_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_user(req_user),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr), .rsp_cause(rsp_cause),
    .pg_req_valid(pg_req_valid), .pg_req_ready(pg_req_ready), .pg_req_vpn(pg_req_vpn),
    .pg_rsp_valid(pg_rsp_valid), .pg_rsp_frame(pg_rsp_frame), .pg_rsp_miss(pg_rsp_miss)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Reference model state
  logic [15:0] mode_m = 16'h0000;
  logic [3:0]  base_m [16];
  logic [33:0] exp_q [$];   // {cause, addr}
  logic [18:0] vpn_q [$];
  bit          rsp_bp = 1'b0;
  bit          pg_bp = 1'b0;

  initial for (int i = 0; i < 16; i++) base_m[i] = 4'h0;

  function automatic logic [18:0] frame_of(logic [18:0] vpn);
    return vpn ^ 19'h2B5C3;
  endfunction

  function automatic bit miss_of(logic [18:0] vpn);
    return vpn[3:0] == 4'hF;
  endfunction

  function automatic bit is_paged(logic [31:0] a, logic u);
    return !(u && a[31:28] >= 4'hB) && !mode_m[a[31:28]];
  endfunction

  function automatic logic [33:0] model(logic [31:0] a, logic u);
    logic [3:0]  s;
    logic [18:0] v;
    s = a[31:28];
    v = a[31:13];
    if (u && s >= 4'hB)   return {2'd1, a};
    if (mode_m[s])        return {2'd0, base_m[s], a[27:0]};
    if (miss_of(v))       return {2'd2, a};
    return {2'd0, frame_of(v), a[12:0]};
  endfunction

  task automatic apply_cfg(logic [1:0] sel, logic [31:0] d);
    if (sel == 2'd0) mode_m = d[15:0];
    else if (sel == 2'd1) for (int i = 0; i < 8; i++) base_m[i]   = d[4*i +: 4];
    else if (sel == 2'd2) for (int i = 0; i < 8; i++) base_m[8+i] = d[4*i +: 4];
  endtask

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  // Push expectations for a request about to be accepted at the next edge
  task automatic push_expect(logic [31:0] a, logic u);
    exp_q.push_back(model(a, u));
    if (is_paged(a, u)) vpn_q.push_back(a[31:13]);
  endtask

  task automatic post_accept_check(bit paged);
    if (paged) check(pg_req_valid == 1'b1, "R5 lookup issued", 64'(pg_req_valid), 64'd1);
    else begin
      check(rsp_valid == 1'b1, "R7 one-cycle response", 64'(rsp_valid), 64'd1);
      check(pg_req_valid == 1'b0, "R7 no lookup", 64'(pg_req_valid), 64'd0);
    end
  endtask

  task automatic send(logic [31:0] a, logic u);
    bit paged;
    req_valid = 1'b1; req_addr = a; req_user = u;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    paged = is_paged(a, u);
    push_expect(a, u);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    #2;
    post_accept_check(paged);
  endtask

  task automatic cfg_write(logic [1:0] sel, logic [31:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk);
    apply_cfg(sel, d);
    @(negedge clk);
    cfg_we = 1'b0;
    #2;
  endtask

  // R3: write and request at the same edge, the request sees the old settings
  task automatic send_with_cfg(logic [31:0] a, logic u, logic [1:0] sel, logic [31:0] d);
    bit paged;
    req_valid = 1'b1; req_addr = a; req_user = u;
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    paged = is_paged(a, u);
    push_expect(a, u);
    @(posedge clk);
    apply_cfg(sel, d);
    @(negedge clk);
    req_valid = 1'b0; cfg_we = 1'b0;
    #2;
    post_accept_check(paged);
  endtask

  // Ready drivers and page-lookup responder
  int          pend_cnt = 0;
  logic [18:0] pend_vpn = 19'd0;

  always @(negedge clk) begin
    rsp_ready = rsp_bp ? ($urandom % 3 != 0) : 1'b1;
    pg_rsp_valid = 1'b0;
    if (pend_cnt > 0) begin
      pg_req_ready = 1'b0;
      pend_cnt--;
      if (pend_cnt == 0) begin
        pg_rsp_valid = 1'b1;
        pg_rsp_frame = frame_of(pend_vpn);
        pg_rsp_miss  = miss_of(pend_vpn);
      end
    end else begin
      pg_req_ready = pg_bp ? ($urandom % 2 == 0) : 1'b1;
      if (pg_req_valid && pg_req_ready) begin
        pend_vpn = pg_req_vpn;
        pend_cnt = pg_bp ? int'($urandom % 3) + 1 : 1;
      end
    end
  end

  // Per-clock comparison against the model
  bit          held = 1'b0;
  logic [33:0] held_val;

  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (held)
        check(rsp_valid && {rsp_cause, rsp_addr} == held_val, "R8 response held",
              64'({rsp_cause, rsp_addr}), 64'(held_val));
      held = rsp_valid && !rsp_ready;
      held_val = {rsp_cause, rsp_addr};
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) check(1'b0, "R8 unexpected response", 64'(rsp_addr), 64'd0);
        else begin
          logic [33:0] e;
          e = exp_q.pop_front();
          if (e[33:32] == 2'd1)
            check({rsp_cause, rsp_addr} == e, "R4 user fault", 64'({rsp_cause, rsp_addr}), 64'(e));
          else if (e[33:32] == 2'd2)
            check({rsp_cause, rsp_addr} == e, "R6 page miss", 64'({rsp_cause, rsp_addr}), 64'(e));
          else
            check({rsp_cause, rsp_addr} == e, "R1 R5 translation", 64'({rsp_cause, rsp_addr}), 64'(e));
        end
      end
      if (pg_req_valid) begin
        if (vpn_q.size() == 0) check(1'b0, "R4 unexpected lookup", 64'(pg_req_vpn), 64'd0);
        else begin
          check(pg_req_vpn == vpn_q[0], "R9 lookup vpn", 64'(pg_req_vpn), 64'(vpn_q[0]));
          if (pg_req_ready) void'(vpn_q.pop_front());
        end
      end
    end
  end

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired at %0t", $time);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    check(req_ready == 1'b1, "R2 reset req_ready", 64'(req_ready), 64'd1);
    check(rsp_valid == 1'b0, "R2 reset rsp_valid", 64'(rsp_valid), 64'd0);
    check(pg_req_valid == 1'b0, "R2 reset pg_req_valid", 64'(pg_req_valid), 64'd0);

    // R2: everything paged after reset
    send(32'hC000_1234, 1'b0);
    send(32'h4000_0000, 1'b0);

    // R3: bases for upper segments (C=4, B=B, E=8, F=0) and lower (4=4, 1=7)
    cfg_write(2'd2, 32'h0804_B000);
    cfg_write(2'd1, 32'h0004_0070);
    send_with_cfg(32'hC000_0010, 1'b0, 2'd0, 32'h0000_D812);  // R3 old mode applies
    send(32'hC000_0010, 1'b0);                                // R3 new mode applies

    // R1 direct mapping across segment edges
    send(32'hCFFF_FFFF, 1'b0);
    send(32'hC000_0000, 1'b0);
    send(32'hB0AB_CDEF, 1'b0);
    send(32'hE123_4567, 1'b0);
    send(32'hF765_4321, 1'b0);
    send(32'h4000_2000, 1'b0);
    send(32'h1ABC_DEF0, 1'b0);

    // R4 user fence at the boundary
    send(32'hAFFF_FFFF, 1'b1);   // paged, vpn ends in F -> R6 miss
    send(32'hA000_0000, 1'b1);   // paged hit
    send(32'hB000_0000, 1'b1);
    send(32'hFFFF_FFFF, 1'b1);
    send(32'hC000_0000, 1'b1);
    send(32'h1ABC_DEF0, 1'b1);

    // R5/R6 kernel paged hit and miss
    send(32'h2001_E000, 1'b0);
    send(32'h2001_C123, 1'b0);
    send(32'hD000_0ABC, 1'b0);

    // R3 rewrite a base
    cfg_write(2'd2, 32'h0805_B000);
    send(32'hC123_4567, 1'b0);

    // R8 stress with stalls on both sides
    rsp_bp = 1'b1;
    pg_bp  = 1'b1;
    for (int i = 0; i < 400; i++) begin
      if (i % 97 == 50) cfg_write(2'(i % 3), $urandom);
      send($urandom, 1'($urandom % 2));
    end
    rsp_bp = 1'b0;
    pg_bp  = 1'b0;

    for (int i = 0; i < 2000 && (exp_q.size() != 0 || rsp_valid); i++) @(negedge clk);
    #3;
    check(exp_q.size() == 0, "R8 all responses delivered", 64'(exp_q.size()), 64'd0);
    check(vpn_q.size() == 0, "R5 all lookups issued", 64'(vpn_q.size()), 64'd0);
    report();
  end

endmodule